// File: doc/BRIEF.md
# SMBus Register-Access Slave with Alert Response

This block is the bus-side front end of a small register bank, such as the one in a temperature or fan monitor. It watches oversampled SCL and SDA lines on the system clock. It pulls SDA low through an open-drain enable. It decodes three SMBus transactions. A send byte loads a persistent register pointer. A write byte loads the pointer and writes one data byte to the bank. A receive byte returns the bank byte at the stored pointer.

The pointer survives across transactions and across a repeated start. The host can therefore set it once and then read the same register many times. The block also takes a local alert input. While an alert is pending, it answers the SMBus alert response address by returning its own address. If another device wins bus arbitration during that reply, the block backs off and keeps its alert pending.

The bank side is a plain synchronous port made of four signals:
- the pointer, driven as the bank address;
- a single-cycle write strobe;
- the write data;
- the combinational read data.

Top module: `smbus_reg_slave`

## Requirements
- R1: After reset, sda_oe_o, reg_we_o and alert_o are 0, and the register pointer on reg_addr_o is 0x00.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A stop at any point releases SDA and abandons the transaction, leaving the pointer unchanged. A new transaction after the stop works normally.
- R3: An address byte is 7 address bits MSB first, then a direction bit (0 = write, 1 = read). If the address equals SLAVE_ADDR, the block drives SDA low during the ninth clock. On any other address it leaves SDA released for the whole transaction, until the next start, and writes nothing.
- R4: Send byte (address+W, command byte, stop) acknowledges the command byte and loads it into the pointer on reg_addr_o. It produces no write strobe.
- R5: Write byte (address+W, command, data) acknowledges the data byte. It then pulses reg_we_o for exactly one cycle, with reg_addr_o equal to the command and reg_wdata_o equal to the data. Any further byte in the same transaction is not acknowledged and is not written.
- R6: Receive byte (address+R) shifts out reg_rdata_i at the stored pointer, MSB first. The pointer is kept, so repeated receive bytes return the same register.
- R7: After a send byte, a repeated start followed by a receive byte returns the register selected by that send byte.
- R8: The block changes SDA only while SCL is low. It samples incoming bits on SCL rising edges and drives outgoing bits after SCL falling edges.
- R9: A rising edge on alert_i sets a pending alert, shown on alert_o. The alert response address 0001100 with the read bit is acknowledged only while the alert is pending. The block then returns {SLAVE_ADDR, 1'b0}, and the pending alert clears once all eight bits have been sent.
- R10: During the alert reply, if the bus reads 0 on a bit where the block sends 1, the block releases SDA for the rest of the transaction and alert_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| alert_i | input | 1 | Local alert request, rising edge sets pending |
| alert_o | output | 1 | Alert pending |
| reg_addr_o | output | 8 | Register pointer / bank address |
| reg_we_o | output | 1 | Single-cycle bank write strobe |
| reg_wdata_o | output | 8 | Bank write data |
| reg_rdata_i | input | 8 | Bank read data at reg_addr_o |

## Verification
The bench builds the block with SLAVE_ADDR = 0x2E, the default ARA_ADDR = 0x0C and two synchronizer stages. The SCL half period is 20 system clocks, so every bus event is seen several cycles after synchronization. The slave address 0x2E differs from the competing responder 0x2C in a single low bit. This puts an arbitration loss late in the alert reply, after several bits the block has already driven itself. Flipping the address LSB gives a near-miss address for the ignore path.

// File: rtl/smbus_pkg.sv
package smbus_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 7;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_SKIP
  } link_st_e;
endpackage

// File: rtl/smbus_line_sync.sv
module smbus_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else if (g == 0) begin
          scl_pipe[g] <= scl_i;
          sda_pipe[g] <= sda_i;
        end else begin
          scl_pipe[g] <= scl_pipe[g-1];
          sda_pipe[g] <= sda_pipe[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_pipe[STAGES-1];
      sda_q <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s_o    = scl_pipe[STAGES-1];
  assign sda_s_o    = sda_pipe[STAGES-1];
  assign start_o    = scl_s_o & scl_q & sda_q & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_q & ~sda_q & sda_s_o;
  assign scl_rise_o = scl_s_o & ~scl_q;
  assign scl_fall_o = ~scl_s_o & scl_q;
endmodule

// File: rtl/smbus_alert_ctrl.sv
module smbus_alert_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic alert_i,
  input  logic clr_i,
  output logic pend_o
);
  logic alert_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alert_q <= 1'b0;
      pend_o  <= 1'b0;
    end else begin
      alert_q <= alert_i;
      // a new request wins over a same-cycle clear
      pend_o  <= (pend_o & ~clr_i) | (alert_i & ~alert_q);
    end
  end

  // R9
  alert_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alert_i && !alert_q) |=> pend_o);
endmodule

// File: rtl/smbus_link_fsm.sv
module smbus_link_fsm
  import smbus_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SLAVE_ADDR = 7'h2E,
  parameter logic [ADDR_W-1:0] ARA_ADDR   = 7'h0C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              alert_pend_i,
  input  logic [BYTE_W-1:0] reg_rdata_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] ptr_o,
  output logic              reg_we_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              ara_done_o
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W - 1);
  localparam logic [BYTE_W-1:0] ARA_REPLY = {SLAVE_ADDR, 1'b0};

  link_st_e          st;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-2:0] rx_sh;
  logic [BYTE_W-2:0] tx_rest;
  logic              ack_on, ack_q, rd_q, ara_q;
  logic [BYTE_W-1:0] rx_byte;
  logic [BYTE_W-1:0] tx_byte;
  logic              arb_lost;

  assign rx_byte  = {rx_sh, sda_i};
  assign tx_byte  = ara_q ? ARA_REPLY : reg_rdata_i;
  assign arb_lost = ara_q & ~sda_oe_o & ~sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st          <= ST_IDLE;
      bit_cnt     <= '0;
      rx_sh       <= '0;
      tx_rest     <= '0;
      ack_on      <= 1'b0;
      ack_q       <= 1'b0;
      rd_q        <= 1'b0;
      ara_q       <= 1'b0;
      sda_oe_o    <= 1'b0;
      ptr_o       <= '0;
      reg_we_o    <= 1'b0;
      reg_wdata_o <= '0;
      ara_done_o  <= 1'b0;
    end else begin
      reg_we_o   <= 1'b0;
      ara_done_o <= 1'b0;
      if (stop_i) begin
        st       <= ST_IDLE;
        sda_oe_o <= 1'b0;
        ack_on   <= 1'b0;
      end else if (start_i) begin
        st       <= ST_ADDR;
        bit_cnt  <= '0;
        sda_oe_o <= 1'b0;
        ack_on   <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (scl_rise_i) begin
              rx_sh   <= rx_byte[BYTE_W-2:0];
              bit_cnt <= bit_cnt + 4'd1;
              if (bit_cnt == LAST_BIT) begin
                bit_cnt <= '0;
                ack_q   <= 1'b1;
                if (st == ST_ADDR) begin
                  if (rx_byte[BYTE_W-1:1] == SLAVE_ADDR) begin
                    rd_q  <= rx_byte[0];
                    ara_q <= 1'b0;
                    st    <= ST_ADDR_ACK;
                  end else if (rx_byte[BYTE_W-1:1] == ARA_ADDR && rx_byte[0] && alert_pend_i) begin
                    rd_q  <= 1'b1;
                    ara_q <= 1'b1;
                    st    <= ST_ADDR_ACK;
                  end else begin
                    st <= ST_SKIP;
                  end
                end else if (st == ST_CMD) begin
                  ptr_o <= rx_byte;
                  st    <= ST_CMD_ACK;
                end else begin
                  ptr_o       <= ptr_o;
                  reg_we_o    <= 1'b1;
                  reg_wdata_o <= rx_byte;
                  st          <= ST_WDATA_ACK;
                end
              end
            end
          end
          ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: begin
            if (scl_fall_i) begin
              if (!ack_on) begin
                ack_on   <= 1'b1;
                sda_oe_o <= ack_q;
              end else begin
                ack_on   <= 1'b0;
                sda_oe_o <= 1'b0;
                bit_cnt  <= '0;
                if (st == ST_ADDR_ACK) begin
                  if (rd_q) begin
                    sda_oe_o <= ~tx_byte[BYTE_W-1];
                    tx_rest  <= tx_byte[BYTE_W-2:0];
                    st       <= ST_TX;
                  end else begin
                    st <= ST_CMD;
                  end
                end else if (st == ST_CMD_ACK) begin
                  st <= ST_WDATA;
                end else begin
                  st <= ST_SKIP;
                end
              end
            end
          end
          ST_TX: begin
            if (scl_rise_i) begin
              bit_cnt <= bit_cnt + 4'd1;
              if (arb_lost) begin
                st <= ST_SKIP;
              end else if (bit_cnt == LAST_BIT) begin
                st         <= ST_TX_ACK;
                ara_done_o <= ara_q;
              end
            end else if (scl_fall_i) begin
              sda_oe_o <= ~tx_rest[BYTE_W-2];
              tx_rest  <= {tx_rest[BYTE_W-3:0], 1'b0};
            end
          end
          ST_TX_ACK: begin
            if (scl_fall_i) sda_oe_o <= 1'b0;
            if (scl_rise_i) st <= ST_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  // R5
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  // R3
  skip_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_SKIP && !start_i && !stop_i) |=> !sda_oe_o);
endmodule

// File: rtl/smbus_reg_slave.sv
module smbus_reg_slave
  import smbus_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SLAVE_ADDR  = 7'h2E,
  parameter logic [ADDR_W-1:0] ARA_ADDR    = 7'h0C,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              alert_i,
  output logic              alert_o,
  output logic [BYTE_W-1:0] reg_addr_o,
  output logic              reg_we_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  logic scl_s, sda_s, start, stop, scl_rise, scl_fall;
  logic ara_done;

  smbus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_s_o    (scl_s),
    .sda_s_o    (sda_s),
    .start_o    (start),
    .stop_o     (stop),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall)
  );

  smbus_alert_ctrl u_alert (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .alert_i (alert_i),
    .clr_i   (ara_done),
    .pend_o  (alert_o)
  );

  smbus_link_fsm #(.SLAVE_ADDR(SLAVE_ADDR), .ARA_ADDR(ARA_ADDR)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .stop_i       (stop),
    .scl_rise_i   (scl_rise),
    .scl_fall_i   (scl_fall),
    .sda_i        (sda_s),
    .alert_pend_i (alert_o),
    .reg_rdata_i  (reg_rdata_i),
    .sda_oe_o     (sda_oe_o),
    .ptr_o        (reg_addr_o),
    .reg_we_o     (reg_we_o),
    .reg_wdata_o  (reg_wdata_o),
    .ara_done_o   (ara_done)
  );

  // R8
  scl_high_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe_o));

  // R2
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> !sda_oe_o);
endmodule

// File: tb/smbus_reg_slave_test.sv
module smbus_reg_slave_test;
  localparam logic [6:0] SA   = 7'h2E;
  localparam logic [6:0] ARA  = 7'h0C;
  localparam int         HALF = 20;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] data;
  } wr_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, comp_sda = 1'b1;
  logic alert = 1'b0;
  logic sda_oe, alert_o, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic sda_bus;
  logic [7:0] mem [256];

  int checks = 0, errors = 0, viol = 0;
  bit done = 1'b0;
  wr_t exp_q[$];

  always #2.5 clk = ~clk;

  assign sda_bus = m_sda & comp_sda & ~sda_oe;

  smbus_reg_slave #(.SLAVE_ADDR(SA), .ARA_ADDR(ARA), .SYNC_STAGES(2)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (m_scl),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .alert_i     (alert),
    .alert_o     (alert_o),
    .reg_addr_o  (reg_addr),
    .reg_we_o    (reg_we),
    .reg_wdata_o (reg_wdata),
    .reg_rdata_i (reg_rdata)
  );

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;
  assign reg_rdata = mem[reg_addr];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: bank writes against expected queue (R5)
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5 unexpected write: actual %0h/%0h expected none", reg_addr, reg_wdata);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        if (e.addr !== reg_addr || e.data !== reg_wdata) begin
          errors++;
          $display("FAIL R5 write: actual %0h/%0h expected %0h/%0h",
                   reg_addr, reg_wdata, e.addr, e.data);
        end
      end
    end
  end

  // R8 monitor: SDA drive must not move while SCL is held high
  logic scl_d = 1'b1, oe_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n && m_scl && scl_d && sda_oe !== oe_d) viol++;
    scl_d = m_scl;
    oe_d  = sda_oe;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; wt(HALF);
    m_sda = 1'b0; wt(HALF);
    m_scl = 1'b0; wt(HALF);
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; wt(HALF);
    m_scl = 1'b1; wt(HALF);
    m_sda = 1'b0; wt(HALF);
    m_scl = 1'b0; wt(HALF);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(HALF);
    m_scl = 1'b1; wt(HALF);
    m_sda = 1'b1; wt(HALF);
  endtask

  task automatic wbit(input logic b);
    m_sda = b; wt(HALF);
    m_scl = 1'b1; wt(HALF);
    m_scl = 1'b0;
  endtask

  task automatic rbit(output logic b, input logic comp);
    m_sda = 1'b1; comp_sda = comp; wt(HALF);
    m_scl = 1'b1; wt(HALF / 2);
    b = sda_bus; wt(HALF / 2);
    m_scl = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(ack, 1'b1);
  endtask

  task automatic rbyte(output logic [7:0] d, input logic [7:0] comp);
    for (int i = 7; i >= 0; i--) rbit(d[i], comp[i]);
    comp_sda = 1'b1;
    wbit(1'b1);
  endtask

  initial begin
    logic ack;
    logic [7:0] rd;
    wt(10);
    // R1
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 reg_we", reg_we, 0);
    chk("R1 pointer", reg_addr, 8'h00);
    chk("R1 alert_o", alert_o, 0);
    rst_n = 1'b1;
    wt(10);

    // R5 write byte
    exp_q.push_back('{addr: 8'h3A, data: 8'h5C});
    bus_start();
    wbyte({SA, 1'b0}, ack); chk("R3 own address ack", ack, 0);
    wbyte(8'h3A, ack);      chk("R5 command ack", ack, 0);
    wbyte(8'h5C, ack);      chk("R5 data ack", ack, 0);
    bus_stop();
    wt(5);
    chk("R5 write consumed", exp_q.size(), 0);

    // R5 extra byte not acknowledged, not written
    exp_q.push_back('{addr: 8'h20, data: 8'h11});
    bus_start();
    wbyte({SA, 1'b0}, ack);
    wbyte(8'h20, ack);
    wbyte(8'h11, ack);
    wbyte(8'h22, ack);      chk("R5 extra byte nack", ack, 1);
    bus_stop();
    wt(5);
    chk("R5 single write", exp_q.size(), 0);
    chk("R5 bank untouched by extra", mem[8'h21], 8'h21 ^ 8'hA5);

    // R4 send byte
    bus_start();
    wbyte({SA, 1'b0}, ack);
    wbyte(8'h3A, ack);      chk("R4 command ack", ack, 0);
    bus_stop();
    wt(5);
    chk("R4 pointer loaded", reg_addr, 8'h3A);

    // R6 receive byte, twice
    bus_start();
    wbyte({SA, 1'b1}, ack); chk("R6 read address ack", ack, 0);
    rbyte(rd, 8'hFF);       chk("R6 read data", rd, 8'h5C);
    bus_stop();
    bus_start();
    wbyte({SA, 1'b1}, ack);
    rbyte(rd, 8'hFF);       chk("R6 pointer persists", rd, 8'h5C);
    bus_stop();

    // R7 send byte + repeated start + receive byte
    bus_start();
    wbyte({SA, 1'b0}, ack);
    wbyte(8'h10, ack);
    bus_rstart();
    wbyte({SA, 1'b1}, ack); chk("R7 read after rstart ack", ack, 0);
    rbyte(rd, 8'hFF);       chk("R7 read data", rd, 8'h10 ^ 8'hA5);
    bus_stop();

    // R3 foreign address ignored
    bus_start();
    wbyte({SA ^ 7'h01, 1'b0}, ack); chk("R3 foreign address nack", ack, 1);
    wbyte(8'h77, ack);              chk("R3 foreign command nack", ack, 1);
    wbyte(8'h99, ack);
    bus_stop();
    wt(5);
    chk("R3 pointer unchanged", reg_addr, 8'h10);

    // R2 stop mid-byte aborts
    bus_start();
    wbyte({SA, 1'b0}, ack);
    wbit(1'b1); wbit(1'b0); wbit(1'b1); wbit(1'b1);
    bus_stop();
    wt(5);
    chk("R2 abort pointer kept", reg_addr, 8'h10);
    chk("R2 abort sda released", sda_oe, 0);
    exp_q.push_back('{addr: 8'h40, data: 8'h66});
    bus_start();
    wbyte({SA, 1'b0}, ack); chk("R2 ack after abort", ack, 0);
    wbyte(8'h40, ack);
    wbyte(8'h66, ack);
    bus_stop();
    wt(5);
    chk("R2 write after abort", exp_q.size(), 0);

    // R9 alert response without pending alert
    bus_start();
    wbyte({ARA, 1'b1}, ack); chk("R9 no pending nack", ack, 1);
    bus_stop();

    // R9 alert response with pending alert
    alert = 1'b1; wt(1); alert = 1'b0; wt(3);
    chk("R9 alert pending", alert_o, 1);
    bus_start();
    wbyte({ARA, 1'b1}, ack); chk("R9 ara ack", ack, 0);
    rbyte(rd, 8'hFF);        chk("R9 ara reply", rd, {SA, 1'b0});
    bus_stop();
    chk("R9 alert cleared", alert_o, 0);

    // R10 arbitration loss against lower address 0x2C
    alert = 1'b1; wt(1); alert = 1'b0; wt(3);
    bus_start();
    wbyte({ARA, 1'b1}, ack);
    rbyte(rd, {7'h2C, 1'b0}); chk("R10 winner byte on bus", rd, {7'h2C, 1'b0});
    bus_stop();
    chk("R10 alert kept", alert_o, 1);
    bus_start();
    wbyte({ARA, 1'b1}, ack); chk("R10 retry ack", ack, 0);
    rbyte(rd, 8'hFF);        chk("R10 retry reply", rd, {SA, 1'b0});
    bus_stop();
    chk("R10 retry clears", alert_o, 0);

    chk("R8 sda stable while scl high", viol, 0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule